// File: doc/BRIEF.md
# Parallel Host Control Register Interface

This block sits between a converter core and a parallel host bus. The host writes 12-bit words. The two top bits of each word pick which of two control registers the word lands in. The block keeps both registers and drives a level-type device reset and a one-cycle sync-generator reset. A configuration bit chooses how the host signals its transfers:

- **Separate mode:** dedicated read and write strobes.
- **Combined mode:** a chip-select strobe plus a direction line.

On reads, the block normally hands the host the converter's current output word. A debug readback mode instead returns the first control register and then the second on the next two reads, and returns converter data again after that. All host pins are asynchronous to the system clock. They pass through synchronizers, and only their edges create transfer events. The async reset is released synchronously inside the block.

Top module: `pbus_ctrl_if`

## Requirements
- R1: A write word whose bits 11:10 are 00 targets register A, and 01 targets register B. Codes 10 and 11 change nothing. A stored register always keeps its own code in bits 11:10.
- R2: After reset, register A reads 0x000 and register B reads 0x430 (bits 4 and 5 set, all others apart from the code bits clear). `rdata` is 0x000, and `dev_rst` and `sync_rst` are low.
- R3: A register B write with bit 0 set returns both registers to their reset values, with bit 0 of B still set, and raises `dev_rst`. While `dev_rst` is high, register A writes are ignored. A register B write with bit 0 clear stores that word and releases `dev_rst`.
- R4: A register B write with bit 1 set makes `sync_rst` high for exactly one clock. Bit 1 is not stored and always reads 0.
- R5: When bit 6 of register B is 0, a write commits the `wdata` present at the rising edge of `wr_n`, and a read is taken at the falling edge of `rd_n`. `cs_n` has no effect in this mode.
- R6: When bit 6 of register B is 1, `wr_n` is a direction line (low means write, high means read). A write commits on the rising edge of `cs_n` while `wr_n` is low, and a read is taken on the falling edge of `cs_n` while `wr_n` is high. `rd_n` has no effect in this mode.
- R7: When bit 9 of register B is 0, each read loads `rdata` with `conv_data` sampled at the read. `rdata` holds its value between reads.
- R8: When bit 9 of register B is 1, the first read after a register B write returns register A, the second returns register B, and later reads return `conv_data`. Every register B write restarts this order. If a read and a write fall in the same cycle, the read is served from the contents and mode that were in place before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read strobe, active low (separate mode) |
| wr_n | input | 1 | Write strobe (separate mode) or direction line (combined mode) |
| cs_n | input | 1 | Transfer strobe, active low (combined mode) |
| wdata | input | 12 | Host write word, bits 11:10 select the register |
| conv_data | input | 12 | Converter output word |
| rdata | output | 12 | Word returned to the host for the latest read |
| cr0_q | output | 12 | Register A contents |
| cr1_q | output | 12 | Register B contents |
| dev_rst | output | 1 | Device reset level (bit 0 of register B) |
| sync_rst | output | 1 | One-clock sync-generator reset pulse |

## Verification
In separate mode, a read and a write can land in the same clock. The bench provokes this by releasing `wr_n` and pulling `rd_n` low at the same instant, so both synchronized edges arrive together. It covers one case where that write switches readback mode on and one where it switches it off. The expected `rdata` is the reply the pre-write contents and mode would give. The next read must then start the readback order again, or fall back to converter data.

// File: rtl/pbus_ctrl_pkg.sv
package pbus_ctrl_pkg;
  localparam int WORD_W = 12;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_CRA = 2'b00;
  localparam logic [SEL_W-1:0] SEL_CRB = 2'b01;

  localparam int B_RESET  = 0;
  localparam int B_SYNC   = 1;
  localparam int B_RWMODE = 6;
  localparam int B_RDBK   = 9;

  localparam logic [WORD_W-1:0] CRA_DEFAULT = 12'h000;
  localparam logic [WORD_W-1:0] CRB_DEFAULT = 12'h430;

  typedef enum logic [1:0] {
    RB_CRA  = 2'd0,
    RB_CRB  = 2'd1,
    RB_DATA = 2'd2
  } rb_state_e;
endpackage

// File: rtl/pbus_strobe_sync.sv
module pbus_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_n[g]};
        prev_q  <= chain_q[LAST];
      end
    end

    assign lvl[g]  = chain_q[LAST];
    assign rise[g] = chain_q[LAST] & ~prev_q;
    assign fall[g] = ~chain_q[LAST] & prev_q;
  end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
  import pbus_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cra_q,
  output logic [WORD_W-1:0] crb_q,
  output logic              sync_q,
  output logic              crb_wr
);
  logic [SEL_W-1:0]  sel;
  logic              hit_a;
  logic              hit_b;
  logic              reg_en;
  logic [WORD_W-1:0] cra_d;
  logic [WORD_W-1:0] crb_d;
  logic              sync_d;

  always_comb begin
    sel    = wdata[WORD_W-1 -: SEL_W];
    hit_b  = wr_evt && (sel == SEL_CRB);
    hit_a  = wr_evt && (sel == SEL_CRA) && !crb_q[B_RESET];
    reg_en = hit_a | hit_b;
    cra_d  = cra_q;
    crb_d  = crb_q;
    if (hit_b) begin
      if (wdata[B_RESET]) begin
        cra_d          = CRA_DEFAULT;
        crb_d          = CRB_DEFAULT;
        crb_d[B_RESET] = 1'b1;
      end else begin
        crb_d          = wdata;
        crb_d[B_SYNC]  = 1'b0;
      end
    end else if (hit_a) begin
      cra_d = wdata;
    end
    sync_d = hit_b & wdata[B_SYNC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cra_q  <= CRA_DEFAULT;
      crb_q  <= CRB_DEFAULT;
      sync_q <= 1'b0;
    end else begin
      if (reg_en) begin
        cra_q <= cra_d;
        crb_q <= crb_d;
      end
      sync_q <= sync_d;
    end
  end

  assign crb_wr = hit_b;
endmodule

// File: rtl/pbus_readback.sv
module pbus_readback
  import pbus_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              rb_en,
  input  logic              rb_restart,
  input  logic [WORD_W-1:0] cra,
  input  logic [WORD_W-1:0] crb,
  input  logic [WORD_W-1:0] conv_data,
  output logic [WORD_W-1:0] rdata_q
);
  rb_state_e         state_q;
  rb_state_e         state_d;
  logic [WORD_W-1:0] rdata_d;
  logic              st_en;

  always_comb begin
    state_d = state_q;
    rdata_d = rdata_q;
    if (rd_evt) begin
      if (rb_en) begin
        unique case (state_q)
          RB_CRA: begin
            rdata_d = cra;
            state_d = RB_CRB;
          end
          RB_CRB: begin
            rdata_d = crb;
            state_d = RB_DATA;
          end
          default: rdata_d = conv_data;
        endcase
      end else begin
        rdata_d = conv_data;
      end
    end
    if (rb_restart) begin
      state_d = RB_CRA;
    end
    st_en = rd_evt | rb_restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RB_CRA;
      rdata_q <= '0;
    end else begin
      if (st_en) begin
        state_q <= state_d;
      end
      if (rd_evt) begin
        rdata_q <= rdata_d;
      end
    end
  end
endmodule

// File: rtl/pbus_ctrl_if.sv
module pbus_ctrl_if
  import pbus_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] conv_data,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] cr0_q,
  output logic [WORD_W-1:0] cr1_q,
  output logic              dev_rst,
  output logic              sync_rst
);
  localparam int NPIN  = 3;
  localparam int P_RD  = 0;
  localparam int P_WR  = 1;
  localparam int P_CS  = 2;

  logic [RST_STAGES-1:0] rst_chain_q;
  logic                  irst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_chain_q <= '0;
    end else begin
      rst_chain_q <= {rst_chain_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign irst_n = rst_chain_q[RST_STAGES-1];

  logic [NPIN-1:0] pin_lvl;
  logic [NPIN-1:0] pin_rise;
  logic [NPIN-1:0] pin_fall;

  pbus_strobe_sync #(
    .N      (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (irst_n),
    .pin_n ({cs_n, wr_n, rd_n}),
    .lvl   (pin_lvl),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  logic combined;
  logic wr_evt;
  logic rd_evt;
  logic crb_wr;

  always_comb begin
    combined = cr1_q[B_RWMODE];
    if (combined) begin
      wr_evt = pin_rise[P_CS] & ~pin_lvl[P_WR];
      rd_evt = pin_fall[P_CS] &  pin_lvl[P_WR];
    end else begin
      wr_evt = pin_rise[P_WR];
      rd_evt = pin_fall[P_RD];
    end
  end

  pbus_regfile u_regs (
    .clk    (clk),
    .rst_n  (irst_n),
    .wr_evt (wr_evt),
    .wdata  (wdata),
    .cra_q  (cr0_q),
    .crb_q  (cr1_q),
    .sync_q (sync_rst),
    .crb_wr (crb_wr)
  );

  pbus_readback u_rdbk (
    .clk        (clk),
    .rst_n      (irst_n),
    .rd_evt     (rd_evt),
    .rb_en      (cr1_q[B_RDBK]),
    .rb_restart (crb_wr),
    .cra        (cr0_q),
    .crb        (cr1_q),
    .conv_data  (conv_data),
    .rdata_q    (rdata)
  );

  assign dev_rst = cr1_q[B_RESET];
endmodule

// File: rtl/pbus_ctrl_if_chk.sv
module pbus_ctrl_if_chk
  import pbus_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_evt,
  input logic              wr_evt,
  input logic [WORD_W-1:0] rdata,
  input logic [WORD_W-1:0] cr0_q,
  input logic [WORD_W-1:0] cr1_q,
  input logic              dev_rst,
  input logic              sync_rst
);
  AST_CRA_CODE: assert property (@(posedge clk) disable iff (!rst_n) cr0_q[11:10] == SEL_CRA); // R1
  AST_CRB_CODE: assert property (@(posedge clk) disable iff (!rst_n) cr1_q[11:10] == SEL_CRB); // R1
  AST_RESET_HOLDS_CRA: assert property (@(posedge clk) disable iff (!rst_n) dev_rst |-> cr0_q == CRA_DEFAULT); // R3
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) sync_rst |=> !sync_rst); // R4
  AST_SYNC_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n) !cr1_q[B_SYNC]); // R4
  AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_evt |=> $stable(cr0_q) && $stable(cr1_q)); // R5
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rd_evt |=> $stable(rdata)); // R7
endmodule

bind pbus_ctrl_if pbus_ctrl_if_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_evt   (rd_evt),
  .wr_evt   (wr_evt),
  .rdata    (rdata),
  .cr0_q    (cr0_q),
  .cr1_q    (cr1_q),
  .dev_rst  (dev_rst),
  .sync_rst (sync_rst)
);

// File: tb/pbus_ctrl_if_tb.sv
module pbus_ctrl_if_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_n, wr_n, cs_n;
  logic [11:0] wdata, conv_data;
  logic [11:0] rdata, cr0_q, cr1_q;
  logic        dev_rst, sync_rst;

  int n_chk = 0;
  int n_fail = 0;
  int sync_seen = 0;
  int m_sync = 0;
  int m_cnt = 0;
  logic [11:0] m_r0 = 12'h000;
  logic [11:0] m_r1 = 12'h430;
  logic [11:0] last_rd = 12'h000;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pbus_ctrl_if u_dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n),
    .wdata(wdata), .conv_data(conv_data), .rdata(rdata),
    .cr0_q(cr0_q), .cr1_q(cr1_q), .dev_rst(dev_rst), .sync_rst(sync_rst)
  );

  always @(negedge clk) if (sync_rst === 1'b1) sync_seen++;

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void m_write(logic [11:0] w);
    if (w[11:10] == 2'b01) begin
      if (w[0]) begin
        m_r0 = 12'h000;
        m_r1 = 12'h431;
      end else begin
        m_r1 = w & 12'hFFD;
      end
      m_cnt = 0;
      if (w[1]) m_sync++;
    end else if (w[11:10] == 2'b00 && !m_r1[0]) begin
      m_r0 = w;
    end
  endfunction

  function automatic logic [11:0] m_read(logic [11:0] c);
    if (!m_r1[9]) return c;
    if (m_cnt == 0) begin m_cnt = 1; return m_r0; end
    if (m_cnt == 1) begin m_cnt = 2; return m_r1; end
    return c;
  endfunction

  task automatic check_state(string req);
    chk(req, cr0_q, m_r0);
    chk(req, cr1_q, m_r1);
    chk("R3 dev_rst level", {11'd0, dev_rst}, {11'd0, m_r1[0]});
    chk("R4 sync pulse count", sync_seen[11:0], m_sync[11:0]);
  endtask

  task automatic do_write(logic [11:0] w);
    bit comb = m_r1[6];
    wdata = w;
    if (!comb) begin
      @(negedge clk) wr_n = 1'b0;
      repeat (3) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      wdata = 12'hC00;
    end else begin
      @(negedge clk) wr_n = 1'b0;
      @(negedge clk) cs_n = 1'b0;
      repeat (3) @(negedge clk);
      cs_n = 1'b1;
      repeat (5) @(negedge clk);
      wdata = 12'hC00;
      @(negedge clk) wr_n = 1'b1;
      repeat (4) @(negedge clk);
    end
    m_write(w);
    check_state(comb ? "R1 R6 combined write" : "R1 R5 separate write");
  endtask

  task automatic do_read(logic [11:0] c);
    bit comb = m_r1[6];
    string lbl = m_r1[9] ? "R8 readback read" : "R7 data read";
    logic [11:0] exp = m_read(c);
    conv_data = c;
    @(negedge clk);
    if (comb) cs_n = 1'b0; else rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(comb ? {lbl, " R6"} : {lbl, " R5"}, rdata, exp);
    cs_n = 1'b1;
    rd_n = 1'b1;
    conv_data = ~c;
    repeat (4) @(negedge clk);
    chk("R7 rdata holds between reads", rdata, exp);
    last_rd = exp;
  endtask

  task automatic stray();
    bit comb = m_r1[6];
    conv_data = 12'(~last_rd);
    @(negedge clk);
    if (comb) rd_n = 1'b0; else cs_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(comb ? "R6 rd_n ignored" : "R5 cs_n ignored", rdata, last_rd);
    check_state(comb ? "R6 rd_n ignored regs" : "R5 cs_n ignored regs");
  endtask

  task automatic collide(logic [11:0] w, logic [11:0] c);
    logic [11:0] exp;
    wdata = w;
    conv_data = c;
    @(negedge clk) wr_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 1'b0;
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    exp = m_read(c);
    m_write(w);
    chk("R8 read beside write", rdata, exp);
    check_state("R5 R8 write beside read");
    last_rd = exp;
    rd_n = 1'b1;
    wdata = 12'hC00;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    wdata = 12'hC00; conv_data = 12'h000;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    chk("R2 reset reg A", cr0_q, 12'h000);
    chk("R2 reset reg B", cr1_q, 12'h430);
    chk("R2 reset rdata", rdata, 12'h000);
    chk("R2 reset dev_rst", {11'd0, dev_rst}, 12'h000);
    chk("R2 reset sync_rst", {11'd0, sync_rst}, 12'h000);

    do_write(12'h2A5);
    do_read(12'h111);
    do_write(12'h600);
    do_read(12'h7E1);
    do_read(12'h7E2);
    do_read(12'h7E3);
    do_read(12'h7E4);
    do_write(12'h600);
    do_read(12'h055);
    do_write(12'h400);
    do_read(12'h0AA);
    do_write(12'h9FF);
    do_write(12'hDFF);
    do_write(12'h403);
    do_write(12'h0FF);
    do_read(12'h321);
    do_write(12'h400);
    stray();
    do_write(12'h442);
    do_write(12'h123);
    do_read(12'h456);
    stray();
    do_write(12'h640);
    do_read(12'hABC);
    do_read(12'hABD);
    do_read(12'hABE);
    do_write(12'h400);
    stray();
    collide(12'h600, 12'h5A5);
    do_read(12'h777);
    collide(12'h400, 12'h3C3);
    do_read(12'h888);

    for (int i = 0; i < 300; i++) begin
      int op = int'($urandom % 9);
      logic [11:0] w;
      case (op)
        0, 1, 2: begin
          w = {2'b01, 10'($urandom)};
          w[0] = (($urandom % 10) == 0);
          do_write(w);
        end
        3, 4: do_write({2'b00, 10'($urandom)});
        5: do_write({1'b1, 11'($urandom)});
        6: stray();
        7: begin
          if (!m_r1[6]) collide({2'b01, 9'($urandom), 1'b0}, 12'($urandom));
          else do_read(12'($urandom));
        end
        default: do_read(12'($urandom));
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule